// File: doc/BRIEF.md
# Capture Trace Register Readout Path

This block moves captured trace samples from a capture clock domain to a host-visible register pair in the system clock domain. Wide samples enter a dual-clock FIFO on the capture side. On the system side, a width splitter presents the sample at the head of the FIFO as a sequence of 32-bit words on one data register. Every read of that register returns the next word and consumes it. A host can therefore pull a whole trace with a burst of reads to one fixed address.

A second register returns the number of 32-bit words waiting to be read. This count includes the words of a sample that has been partly read. The host reads this count once and then issues that many data reads, without checking a flag on every word. A read of the data register when nothing is stored returns zero and changes nothing.

Top module: `cap_readout`

## Requirements
- R1: A synchronous reset (capRst in the capture domain, sysRst in the system domain) empties the FIFO and clears the slice position. After it, the level register reads 0, data reads return 0, capFull is low and regRdData is 0.
- R2: A read strobe with regAddr equal to 0 (data register) returns the words of each stored sample in arrival order. Within a sample, bits [31:0] come first and bits [63:32] second. The second word consumes the sample.
- R3: A read strobe with regAddr equal to 1 (level register) returns, zero-extended in bits [31:0], the count of 32-bit words still unread. Each stored sample counts as 2 words, minus the words already read from the head sample.
- R4: A read strobe at any address other than 0 changes neither the FIFO read position nor the slice position. At any address other than 0 or 1 the read returns 0.
- R5: A data read while the FIFO holds no sample returns 0 and leaves all pointers unchanged. The next stored sample is then returned starting from its low word.
- R6: capFull is high while the FIFO holds DEPTH samples (8 by default). A capture write (capValid high) while capFull is high is dropped, and the level stays at 2*DEPTH words.
- R7: regRdData updates only on the clock edge that takes a read strobe. It holds its value on every cycle without a strobe.
- R8: A sample written in the capture domain appears in the level register within a few system cycles. Once the host has read it, the space is returned to the capture side within a few capture cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| capClk | input | 1 | Capture domain clock |
| capRst | input | 1 | Synchronous reset, capture domain |
| capValid | input | 1 | Capture sample write request |
| capData | input | 64 | Capture sample |
| capFull | output | 1 | FIFO holds DEPTH samples; writes are dropped |
| sysClk | input | 1 | System domain clock |
| sysRst | input | 1 | Synchronous reset, system domain |
| regRdStb | input | 1 | Register read strobe, one cycle per read |
| regAddr | input | 4 | Word address of the register being read |
| regRdData | output | 32 | Read response, valid the cycle after the strobe |

## Verification
A wrong slice position would show on the very next data read as swapped halves or a repeated word. The level register would also be off by one word at once. A read pointer that moves on a level read or an empty read shows as a skipped sample on the following data read, and a pointer that fails to move shows as a repeated sample. A broken domain crossing shows as a level that never rises after a write, or as a capFull that never clears after draining, both within a few cycles.

// File: rtl/cap_readout_pkg.sv
package cap_readout_pkg;

  // Strobes from the register decode to the datapath
  typedef struct packed {
    logic load;      // any read this cycle: update the response register
    logic selData;   // read targets the data register
    logic selLevel;  // read targets the level register
    logic advance;   // data read with a sample present: consume one word
  } rdStrobe_t;

endpackage

// File: rtl/cap_cdc_fifo.sv
module cap_cdc_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              capClk,
  input  logic              capRst,
  input  logic              capValid,
  input  logic [DATA_W-1:0] capData,
  output logic              capFull,
  output logic [PTR_W:0]    wrPtrBin,
  input  logic              sysClk,
  input  logic              sysRst,
  input  logic              popEn,
  output logic [DATA_W-1:0] headData,
  output logic [PTR_W:0]    fillCount,
  output logic              fifoEmpty,
  output logic [PTR_W:0]    rdPtrBin
);

  function automatic logic [PTR_W:0] toGray(input logic [PTR_W:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W:0] fromGray(input logic [PTR_W:0] g);
    logic [PTR_W:0] b;
    b[PTR_W] = g[PTR_W];
    for (int i = PTR_W - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  // capture side
  logic [PTR_W:0] wrGray;
  logic [PTR_W:0] rdGraySync1, rdGraySync2;
  logic [PTR_W:0] rdBinAtCap;
  logic           capPush;

  assign rdBinAtCap = fromGray(rdGraySync2);
  assign capFull    = (wrPtrBin - rdBinAtCap) == (PTR_W+1)'(DEPTH);
  assign capPush    = capValid && !capFull;

  always_ff @(posedge capClk) begin
    if (capRst) begin
      wrPtrBin    <= '0;
      wrGray      <= '0;
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
    end else begin
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
      if (capPush) begin
        wrPtrBin <= wrPtrBin + 1'b1;
        wrGray   <= toGray(wrPtrBin + 1'b1);
      end
    end
  end

  always_ff @(posedge capClk) begin
    if (capPush) mem[wrPtrBin[PTR_W-1:0]] <= capData;
  end

  // system side
  logic [PTR_W:0] rdGray;
  logic [PTR_W:0] wrGraySync1, wrGraySync2;
  logic [PTR_W:0] wrBinAtSys;

  assign wrBinAtSys = fromGray(wrGraySync2);
  assign fillCount  = wrBinAtSys - rdPtrBin;
  assign fifoEmpty  = (fillCount == '0);
  assign headData   = mem[rdPtrBin[PTR_W-1:0]];

  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      rdPtrBin    <= '0;
      rdGray      <= '0;
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
    end else begin
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
      if (popEn && !fifoEmpty) begin
        rdPtrBin <= rdPtrBin + 1'b1;
        rdGray   <= toGray(rdPtrBin + 1'b1);
      end
    end
  end

endmodule

// File: rtl/cap_readout_ctrl.sv
module cap_readout_ctrl
  import cap_readout_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_ADDR  = 0,
  parameter int LEVEL_ADDR = 1
) (
  input  logic              regRdStb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              fifoEmpty,
  output rdStrobe_t         strobe
);

  logic hitData, hitLevel;

  assign hitData  = (regAddr == ADDR_W'(DATA_ADDR));
  assign hitLevel = (regAddr == ADDR_W'(LEVEL_ADDR));

  always_comb begin
    strobe          = '0;
    strobe.load     = regRdStb;
    strobe.selData  = regRdStb && hitData;
    strobe.selLevel = regRdStb && hitLevel;
    strobe.advance  = regRdStb && hitData && !fifoEmpty;
  end

endmodule

// File: rtl/cap_readout_dp.sv
module cap_readout_dp
  import cap_readout_pkg::*;
#(
  parameter int SAMPLE_W = 64,
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 8,
  localparam int RATIO   = SAMPLE_W / WORD_W,
  localparam int SLICE_W = (RATIO > 1) ? $clog2(RATIO) : 1,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int LVL_W   = $clog2(DEPTH * RATIO + 1)
) (
  input  logic                sysClk,
  input  logic                sysRst,
  input  rdStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] headData,
  input  logic [PTR_W:0]      fillCount,
  output logic                popEn,
  output logic [SLICE_W-1:0]  sliceIdx,
  output logic [LVL_W-1:0]    levelWords,
  output logic [WORD_W-1:0]   regRdData
);

  logic [WORD_W-1:0] slices [RATIO];
  logic [WORD_W-1:0] curWord;
  logic              lastSlice;

  for (genvar g = 0; g < RATIO; g++) begin : g_slice
    assign slices[g] = headData[g*WORD_W +: WORD_W];
  end

  assign curWord    = slices[sliceIdx];
  assign lastSlice  = (sliceIdx == SLICE_W'(RATIO - 1));
  assign popEn      = strobe.advance && lastSlice;
  assign levelWords = LVL_W'(fillCount) * LVL_W'(RATIO) - LVL_W'(sliceIdx);

  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      sliceIdx <= '0;
    end else if (strobe.advance) begin
      sliceIdx <= lastSlice ? '0 : sliceIdx + 1'b1;
    end
  end

  always_ff @(posedge sysClk) begin
    if (sysRst) begin
      regRdData <= '0;
    end else if (strobe.load) begin
      if (strobe.selData)       regRdData <= strobe.advance ? curWord : '0;
      else if (strobe.selLevel) regRdData <= WORD_W'(levelWords);
      else                      regRdData <= '0;
    end
  end

endmodule

// File: rtl/cap_readout.sv
module cap_readout
  import cap_readout_pkg::*;
#(
  parameter int SAMPLE_W   = 64,
  parameter int WORD_W     = 32,
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 4,
  parameter int DATA_ADDR  = 0,
  parameter int LEVEL_ADDR = 1,
  localparam int RATIO     = SAMPLE_W / WORD_W,
  localparam int SLICE_W   = (RATIO > 1) ? $clog2(RATIO) : 1,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int LVL_W     = $clog2(DEPTH * RATIO + 1)
) (
  input  logic                capClk,
  input  logic                capRst,
  input  logic                capValid,
  input  logic [SAMPLE_W-1:0] capData,
  output logic                capFull,
  input  logic                sysClk,
  input  logic                sysRst,
  input  logic                regRdStb,
  input  logic [ADDR_W-1:0]   regAddr,
  output logic [WORD_W-1:0]   regRdData
);

  rdStrobe_t           strobe;
  logic                popEn;
  logic                fifoEmpty;
  logic [SAMPLE_W-1:0] headData;
  logic [PTR_W:0]      fillCount;
  logic [PTR_W:0]      rdPtrBin;
  logic [PTR_W:0]      wrPtrBin;
  logic [SLICE_W-1:0]  sliceIdx;
  logic [LVL_W-1:0]    levelWords;

  cap_cdc_fifo #(.DATA_W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .capClk(capClk), .capRst(capRst), .capValid(capValid), .capData(capData),
    .capFull(capFull), .wrPtrBin(wrPtrBin),
    .sysClk(sysClk), .sysRst(sysRst), .popEn(popEn), .headData(headData),
    .fillCount(fillCount), .fifoEmpty(fifoEmpty), .rdPtrBin(rdPtrBin)
  );

  cap_readout_ctrl #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .LEVEL_ADDR(LEVEL_ADDR)) u_ctrl (
    .regRdStb(regRdStb), .regAddr(regAddr), .fifoEmpty(fifoEmpty), .strobe(strobe)
  );

  cap_readout_dp #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_dp (
    .sysClk(sysClk), .sysRst(sysRst), .strobe(strobe), .headData(headData),
    .fillCount(fillCount), .popEn(popEn), .sliceIdx(sliceIdx),
    .levelWords(levelWords), .regRdData(regRdData)
  );

endmodule

// File: rtl/cap_readout_chk.sv
module cap_readout_chk #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 8,
  parameter int RATIO     = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_ADDR = 0,
  parameter int SLICE_W   = 1,
  parameter int PTR_W     = 3,
  parameter int LVL_W     = 5
) (
  input logic               capClk,
  input logic               capRst,
  input logic               capValid,
  input logic               capFull,
  input logic [PTR_W:0]     wrPtrBin,
  input logic               sysClk,
  input logic               sysRst,
  input logic               regRdStb,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [WORD_W-1:0]  regRdData,
  input logic               fifoEmpty,
  input logic [PTR_W:0]     rdPtrBin,
  input logic [SLICE_W-1:0] sliceIdx,
  input logic [LVL_W-1:0]   levelWords
);

  logic dataRd;
  assign dataRd = regRdStb && (regAddr == ADDR_W'(DATA_ADDR));

  // R1: reset clears the response and the slice position
  assert_reset_clear_R1: assert property (@(posedge sysClk)
    sysRst |=> (regRdData == '0) && (sliceIdx == '0));

  // R2: reading the last word of a sample moves to the next sample
  assert_pop_on_last_R2: assert property (@(posedge sysClk) disable iff (sysRst)
    (dataRd && !fifoEmpty && sliceIdx == SLICE_W'(RATIO - 1))
      |=> (sliceIdx == '0) && (rdPtrBin == $past(rdPtrBin) + 1'b1));

  // R3: the level never exceeds what the storage can hold
  assert_level_bound_R3: assert property (@(posedge sysClk) disable iff (sysRst)
    levelWords <= LVL_W'(DEPTH * RATIO));

  // R4: reads of other addresses leave the stream untouched
  assert_no_side_effect_R4: assert property (@(posedge sysClk) disable iff (sysRst)
    (regRdStb && !dataRd) |=> $stable(rdPtrBin) && $stable(sliceIdx));

  // R5: an empty data read returns zero and moves nothing
  assert_empty_zero_R5: assert property (@(posedge sysClk) disable iff (sysRst)
    (dataRd && fifoEmpty) |=> (regRdData == '0) && $stable(rdPtrBin) && $stable(sliceIdx));

  // R6: a write while full is dropped
  assert_no_overflow_R6: assert property (@(posedge capClk) disable iff (capRst)
    (capValid && capFull) |=> $stable(wrPtrBin));

  // R7: the response holds between strobes
  assert_rdata_hold_R7: assert property (@(posedge sysClk) disable iff (sysRst)
    !regRdStb |=> $stable(regRdData));

endmodule

bind cap_readout cap_readout_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .RATIO(RATIO), .ADDR_W(ADDR_W),
  .DATA_ADDR(DATA_ADDR), .SLICE_W(SLICE_W), .PTR_W(PTR_W), .LVL_W(LVL_W)
) u_chk (
  .capClk(capClk), .capRst(capRst), .capValid(capValid), .capFull(capFull),
  .wrPtrBin(wrPtrBin), .sysClk(sysClk), .sysRst(sysRst), .regRdStb(regRdStb),
  .regAddr(regAddr), .regRdData(regRdData), .fifoEmpty(fifoEmpty),
  .rdPtrBin(rdPtrBin), .sliceIdx(sliceIdx), .levelWords(levelWords)
);

// File: tb/cap_readout_bench.sv
`timescale 1ns/1ps
module cap_readout_bench;

  localparam int DEPTH = 8;
  localparam int RATIO = 2;

  logic        capClk = 0, capRst = 1, capValid = 0;
  logic [63:0] capData = '0;
  logic        capFull;
  logic        sysClk = 0, sysRst = 1, regRdStb = 0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regRdData;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [31:0] wq[$];

  always #5  sysClk = ~sysClk;
  always #13 capClk = ~capClk;

  cap_readout u_cap_readout (
    .capClk(capClk), .capRst(capRst), .capValid(capValid), .capData(capData),
    .capFull(capFull), .sysClk(sysClk), .sysRst(sysRst), .regRdStb(regRdStb),
    .regAddr(regAddr), .regRdData(regRdData)
  );

  function automatic int heldSamples();
    return (wq.size() + RATIO - 1) / RATIO;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sysRead(input logic [3:0] addr, output logic [31:0] val);
    @(negedge sysClk);
    regRdStb = 1; regAddr = addr;
    @(negedge sysClk);
    regRdStb = 0;
    val = regRdData;
  endtask

  task automatic settle();
    repeat (14) @(negedge sysClk);
  endtask

  task automatic capWrite(input logic [63:0] d);
    @(negedge capClk);
    if (heldSamples() < DEPTH) begin
      wq.push_back(d[31:0]);
      wq.push_back(d[63:32]);
    end
    capValid = 1; capData = d;
    @(negedge capClk);
    capValid = 0;
  endtask

  task automatic doReset();
    capRst = 1; sysRst = 1;
    repeat (4) @(negedge capClk);
    capRst = 0;
    @(negedge sysClk);
    sysRst = 0;
    wq.delete();
    settle();
  endtask

  task automatic readData(input string tag);
    logic [31:0] v, e;
    e = (wq.size() == 0) ? 32'h0 : wq.pop_front();
    sysRead(4'd0, v);
    check(v == e, tag, v, e);
  endtask

  task automatic readLevel(input string tag);
    logic [31:0] v;
    sysRead(4'd1, v);
    check(v == 32'(wq.size()), tag, v, 32'(wq.size()));
  endtask

  initial begin
    logic [31:0] v, hold;
    void'($urandom(32'd4242));
    doReset();

    // R1: reset state
    check(capFull == 1'b0, "R1 capFull after reset", 32'(capFull), 0);
    check(regRdData == 0, "R1 regRdData after reset", regRdData, 0);
    readLevel("R1 level after reset");
    readData("R1 data read after reset");

    // R2/R3/R4: basic stream with interleaved level and stray reads
    capWrite(64'h1111_2222_3333_4444);
    capWrite(64'hAAAA_BBBB_CCCC_DDDD);
    capWrite({$urandom, $urandom});
    settle();
    readLevel("R3 level after three samples");
    readData("R2 low word first");
    readLevel("R3 level counts partial sample");
    sysRead(4'd5, v);
    check(v == 0, "R4 unmapped read returns zero", v, 0);
    readLevel("R4 level unchanged by stray read");
    readData("R2 high word second");
    for (int i = 0; i < 4; i++) readData("R2 stream order");
    readLevel("R3 level after drain");

    // R5: empty reads
    readData("R5 empty read zero");
    readData("R5 second empty read zero");
    capWrite(64'h0123_4567_89AB_CDEF);
    settle();
    readData("R5 low word after empty reads");
    readData("R5 high word after empty reads");

    // R6: overflow
    for (int i = 0; i < DEPTH + 3; i++) capWrite({$urandom, 32'(i)});
    settle();
    check(capFull == 1'b1, "R6 capFull at depth", 32'(capFull), 1);
    readLevel("R6 level at full");
    for (int i = 0; i < DEPTH * RATIO; i++) readData("R6 drained data");
    settle();
    check(capFull == 1'b0, "R8 capFull clears after drain", 32'(capFull), 0);

    // R7: response holds between strobes
    capWrite(64'hFEED_FACE_DEAD_BEEF);
    settle();
    readData("R7 data before hold");
    hold = regRdData;
    repeat (5) @(negedge sysClk);
    check(regRdData == hold, "R7 response held", regRdData, hold);

    // Random mix of write bursts and reads
    for (int it = 0; it < 150; it++) begin
      int nw = $urandom_range(0, 3);
      int nr = $urandom_range(1, 6);
      for (int w = 0; w < nw; w++) capWrite({$urandom, $urandom});
      settle();
      check(capFull == (heldSamples() >= DEPTH), "R6 capFull vs model",
            32'(capFull), 32'(heldSamples() >= DEPTH));
      for (int r = 0; r < nr; r++) begin
        case ($urandom_range(0, 3))
          0, 1: readData("R2 random data");
          2:    readLevel("R3 random level");
          default: begin
            sysRead(4'(2 + $urandom_range(0, 13)), v);
            check(v == 0, "R4 random stray read", v, 0);
          end
        endcase
      end
      settle();
    end

    // R1: reset in the middle of a sample
    capWrite(64'h5555_6666_7777_8888);
    capWrite(64'h9999_0000_1212_3434);
    settle();
    readData("R2 before mid reset");
    doReset();
    readLevel("R1 level after mid reset");
    readData("R1 data after mid reset");
    check(capFull == 1'b0, "R1 capFull after mid reset", 32'(capFull), 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge sysClk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule